// File: doc/BRIEF.md
# Four-Phase Dual-Rail Channel Interface

This block is a clocked model of a delay-insensitive push channel. A transmit side accepts a parallel word over a valid/ready interface and places it on a pair of wires per bit. It then waits for the receiver's acknowledge, replaces the code with an all-empty spacer, and waits for the acknowledge to fall before it takes the next word. No request wire exists. The presence of data is carried by the code itself.

The receive side decodes each bit pair on its own. It treats the word as present only when every pair holds a valid code, and as gone only when every pair has returned to empty. Between those two states a completion flag keeps its value, in the way a C-element does. The flag drives the acknowledge. When the flag rises, the decoded word is presented for one cycle. A pair showing both wires high sets a sticky error flag. Both sides sample all handshake wires once per clock, so the two halves can be joined through wires of unequal delay.

Top module: `dualRailChannel`

## Requirements
- R1: Each bit uses a true wire and a false wire. A bit of value 1 is sent as true=1, false=0. A bit of value 0 is sent as true=0, false=1. Empty is both wires 0, and the transmitter never drives both wires high.
- R2: `inReady` is high only while the transmitter is idle. A word is taken at a clock edge where `inValid` and `inReady` are both high, and its code appears on the transmit rails right after that edge. `inValid` and `inData` have no effect while `inReady` is low.
- R3: The transmitter holds the valid code until it samples `txAck` high. From the following cycle it drives all-empty and keeps doing so until it samples `txAck` low. It becomes ready in the cycle after that.
- R4: No transmit bit moves from one valid code directly to the other valid code. Every change between words passes through empty.
- R5: `rxAck` rises in the cycle after the first clock edge at which every receive pair is valid. A word in which only some pairs are valid leaves `rxAck` low.
- R6: `rxAck` falls in the cycle after the first clock edge at which every receive pair is empty. While any pair is still non-empty, `rxAck` stays high.
- R7: `outValid` is a one-cycle pulse in the same cycle in which `rxAck` rises. During that pulse `outData` carries the true rails captured at that edge.
- R8: `protoErr` rises after any edge at which some receive pair is 11. It stays high until reset.
- R9: After reset the transmit rails are empty, `inReady` is 1, and `rxAck`, `outValid` and `protoErr` are 0.
- R10: When each bit path between the two sides is delayed by 0 to 3 cycles, every word is delivered once, in the order it was sent, with its value intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Producer has a word |
| inReady | output | 1 | Transmitter can take a word |
| inData | input | W | Word to send |
| txTrue | output | W | Transmit true rails |
| txFalse | output | W | Transmit false rails |
| txAck | input | 1 | Acknowledge returned to the transmitter |
| rxTrue | input | W | Receive true rails |
| rxFalse | input | W | Receive false rails |
| rxAck | output | 1 | Acknowledge driven by the receiver |
| outData | output | W | Decoded word |
| outValid | output | 1 | One-cycle pulse when a word completes |
| protoErr | output | 1 | Sticky flag for an illegal 11 pair |

## Verification
The hardest case to reach is the receiver's hysteresis: a word that is partly valid, or partly returned to empty, must not move the acknowledge. When the two sides are wired together, these partial states last only a few cycles. The bench therefore drives the receive rails directly and holds mixed words for several cycles, and it also checks the 11 code. It then joins the two sides through per-bit delay lines with random taps. Each word travels through its own set of skews, so the receiver sees bits arrive and leave in a scattered order.

// File: rtl/drChanPkg.sv
package drChanPkg;

  typedef enum logic [1:0] {
    TX_IDLE   = 2'd0,
    TX_DATA   = 2'd1,
    TX_SPACER = 2'd2
  } txState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadWord;
    logic driveRails;
    logic captureWord;
  } drStrobe_t;

endpackage

// File: rtl/drChanPath.sv
module drChanPath
  import drChanPkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  drStrobe_t    strobe,
  input  logic [W-1:0] inData,
  output logic [W-1:0] txTrue,
  output logic [W-1:0] txFalse,
  input  logic [W-1:0] rxTrue,
  input  logic [W-1:0] rxFalse,
  output logic         allValid,
  output logic         allEmpty,
  output logic [W-1:0] outData,
  output logic         outValid,
  output logic         protoErr
);

  logic [W-1:0] txWord;
  logic [W-1:0] bitValid;
  logic [W-1:0] bitEmpty;
  logic [W-1:0] bitBad;

  // transmit encoding: true rail carries the bit, false rail its complement
  always_comb begin
    txTrue  = strobe.driveRails ? txWord  : '0;
    txFalse = strobe.driveRails ? ~txWord : '0;
  end

  // per-bit completion detection
  for (genvar b = 0; b < W; b++) begin : gPair
    assign bitValid[b] = rxTrue[b] ^ rxFalse[b];
    assign bitEmpty[b] = ~(rxTrue[b] | rxFalse[b]);
    assign bitBad[b]   = rxTrue[b] & rxFalse[b];
  end

  assign allValid = &bitValid;
  assign allEmpty = &bitEmpty;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txWord   <= '0;
      outData  <= '0;
      outValid <= 1'b0;
      protoErr <= 1'b0;
    end else begin
      if (strobe.loadWord) txWord <= inData;
      if (strobe.captureWord) outData <= rxTrue;
      outValid <= strobe.captureWord;
      protoErr <= protoErr | (|bitBad);
    end
  end

endmodule

// File: rtl/drChanCtrl.sv
module drChanCtrl
  import drChanPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      inValid,
  input  logic      txAck,
  input  logic      allValid,
  input  logic      allEmpty,
  output logic      inReady,
  output logic      rxAck,
  output drStrobe_t strobe
);

  txState_t txState, txNext;
  logic     complete;

  always_comb begin
    txNext = txState;
    unique case (txState)
      TX_IDLE:   if (inValid) txNext = TX_DATA;
      TX_DATA:   if (txAck) txNext = TX_SPACER;
      TX_SPACER: if (!txAck) txNext = TX_IDLE;
      default:   txNext = TX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txState  <= TX_IDLE;
      complete <= 1'b0;
    end else begin
      txState <= txNext;
      // C-element style hysteresis on word completion
      if (allValid) complete <= 1'b1;
      else if (allEmpty) complete <= 1'b0;
    end
  end

  always_comb begin
    inReady            = (txState == TX_IDLE);
    rxAck              = complete;
    strobe.loadWord    = (txState == TX_IDLE) && inValid;
    strobe.driveRails  = (txState == TX_DATA);
    strobe.captureWord = allValid && !complete;
  end

endmodule

// File: rtl/dualRailChannel.sv
module dualRailChannel
  import drChanPkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  output logic         inReady,
  input  logic [W-1:0] inData,
  output logic [W-1:0] txTrue,
  output logic [W-1:0] txFalse,
  input  logic         txAck,
  input  logic [W-1:0] rxTrue,
  input  logic [W-1:0] rxFalse,
  output logic         rxAck,
  output logic [W-1:0] outData,
  output logic         outValid,
  output logic         protoErr
);

  drStrobe_t strobe;
  logic      allValid;
  logic      allEmpty;

  drChanCtrl i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .txAck   (txAck),
    .allValid(allValid),
    .allEmpty(allEmpty),
    .inReady (inReady),
    .rxAck   (rxAck),
    .strobe  (strobe)
  );

  drChanPath #(.W(W)) i_path (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .inData  (inData),
    .txTrue  (txTrue),
    .txFalse (txFalse),
    .rxTrue  (rxTrue),
    .rxFalse (rxFalse),
    .allValid(allValid),
    .allEmpty(allEmpty),
    .outData (outData),
    .outValid(outValid),
    .protoErr(protoErr)
  );

endmodule

// File: rtl/dualRailChannelChk.sv
module dualRailChannelChk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rstN,
  input logic         inValid,
  input logic         inReady,
  input logic [W-1:0] txTrue,
  input logic [W-1:0] txFalse,
  input logic         txAck,
  input logic [W-1:0] rxTrue,
  input logic [W-1:0] rxFalse,
  input logic         rxAck,
  input logic         outValid,
  input logic         protoErr
);

  // R1
  tx_no_illegal_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txTrue & txFalse) == '0);

  // R2
  tx_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> ((txTrue ^ txFalse) == {W{1'b1}}));

  // R3
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (((txTrue ^ txFalse) == {W{1'b1}}) && !txAck) |=> ($stable(txTrue) && $stable(txFalse)));

  // R4
  for (genvar b = 0; b < W; b++) begin : gSwap
    no_valid_swap_chk: assert property (@(posedge clk) disable iff (!rstN)
      ((txTrue[b] ^ txFalse[b]) && $past(txTrue[b] ^ txFalse[b])) |-> (txTrue[b] == $past(txTrue[b])));
  end

  // R6
  ack_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxAck && ((rxTrue | rxFalse) != '0)) |=> rxAck);

  // R7
  out_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |=> !outValid);

  // R7
  out_with_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $rose(rxAck));

  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    protoErr |=> protoErr);

endmodule

bind dualRailChannel dualRailChannelChk #(.W(W)) i_chk (
  .clk     (clk),
  .rstN    (rstN),
  .inValid (inValid),
  .inReady (inReady),
  .txTrue  (txTrue),
  .txFalse (txFalse),
  .txAck   (txAck),
  .rxTrue  (rxTrue),
  .rxFalse (rxFalse),
  .rxAck   (rxAck),
  .outValid(outValid),
  .protoErr(protoErr)
);

// File: tb/test_dualRailChannel.sv
`timescale 1ns/1ps
module test_dualRailChannel;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         inValid = 1'b0;
  logic         inReady;
  logic [W-1:0] inData = '0;
  logic [W-1:0] txTrue, txFalse;
  logic         txAck;
  logic [W-1:0] rxTrue, rxFalse;
  logic         rxAck;
  logic [W-1:0] outData;
  logic         outValid;
  logic         protoErr;

  // bench-side channel wiring
  logic         ackSel = 1'b0;
  logic         ackDrv = 1'b0;
  logic         rxSel = 1'b0;
  logic [W-1:0] manT = '0, manF = '0;
  logic [2:0]   lineT [W];
  logic [2:0]   lineF [W];
  logic [1:0]   tap [W];
  logic [W-1:0] skT, skF;

  int checks = 0;
  int fails = 0;
  int swapErr = 0;
  bit done = 0;
  bit streamOn = 0;
  int rxCount = 0;
  logic [W-1:0] sent [64];
  logic [W-1:0] prevT = '0, prevF = '0;

  always #2 clk = ~clk;

  dualRailChannel #(.W(W)) i_dualRailChannel (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady), .inData(inData),
    .txTrue(txTrue), .txFalse(txFalse), .txAck(txAck),
    .rxTrue(rxTrue), .rxFalse(rxFalse), .rxAck(rxAck),
    .outData(outData), .outValid(outValid), .protoErr(protoErr)
  );

  initial for (int b = 0; b < W; b++) begin
    tap[b] = 2'd0; lineT[b] = '0; lineF[b] = '0;
  end

  always @(posedge clk)
    for (int b = 0; b < W; b++) begin
      lineT[b] <= {lineT[b][1:0], txTrue[b]};
      lineF[b] <= {lineF[b][1:0], txFalse[b]};
    end

  always_comb
    for (int b = 0; b < W; b++) begin
      skT[b] = (tap[b] == 2'd0) ? txTrue[b]  : lineT[b][tap[b] - 2'd1];
      skF[b] = (tap[b] == 2'd0) ? txFalse[b] : lineF[b][tap[b] - 2'd1];
    end

  assign rxTrue  = rxSel ? manT : skT;
  assign rxFalse = rxSel ? manF : skF;
  assign txAck   = ackSel ? ackDrv : rxAck;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // R4 monitor on the transmit rails
  always @(negedge clk) begin
    if (rstN)
      for (int b = 0; b < W; b++)
        if ((prevT[b] ^ prevF[b]) && (txTrue[b] ^ txFalse[b]) && (txTrue[b] != prevT[b]))
          swapErr++;
    prevT <= txTrue;
    prevF <= txFalse;
  end

  // R10 / R7 delivery monitor
  always @(negedge clk)
    if (streamOn && outValid) begin
      if (rxCount < 64) check("R10 word order", outData, sent[rxCount]);
      check("R7 ack with pulse", rxAck, 1'b1);
      rxCount++;
    end

  task automatic testReset;
    rstN = 1'b0;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R9 tx rails empty", {txTrue, txFalse}, '0);
    check("R9 inReady", inReady, 1'b1);
    check("R9 rxAck", rxAck, 1'b0);
    check("R9 outValid", outValid, 1'b0);
    check("R9 protoErr", protoErr, 1'b0);
  endtask

  task automatic testTransmit;
    ackSel = 1'b1; ackDrv = 1'b0;
    inValid = 1'b1; inData = 8'hA5;
    @(negedge clk);
    inValid = 1'b1; inData = 8'h3C;   // offered while busy: must be ignored
    check("R1 true rails", txTrue, 8'hA5);
    check("R1 false rails", txFalse, 8'h5A);
    check("R2 not ready while busy", inReady, 1'b0);
    repeat (3) @(negedge clk);
    inValid = 1'b0;
    check("R3 code held", txTrue, 8'hA5);
    check("R2 busy offer ignored", txFalse, 8'h5A);
    ackDrv = 1'b1;
    @(negedge clk);
    check("R3 spacer after ack", {txTrue, txFalse}, '0);
    repeat (2) @(negedge clk);
    check("R3 spacer held", {txTrue, txFalse}, '0);
    check("R3 wait ack low", inReady, 1'b0);
    ackDrv = 1'b0;
    @(negedge clk);
    check("R3 ready after ack low", inReady, 1'b1);
    repeat (6) @(negedge clk);
    ackSel = 1'b0;
  endtask

  task automatic testReceive;
    rxSel = 1'b1; ackSel = 1'b1; ackDrv = 1'b0;
    manT = 8'h0F; manF = 8'h30;   // bits 7:6 still empty
    @(negedge clk);
    check("R5 partial valid no ack", rxAck, 1'b0);
    check("R5 partial valid no out", outValid, 1'b0);
    manT = 8'h8F; manF = 8'h70;
    @(negedge clk);
    check("R5 ack on full word", rxAck, 1'b1);
    check("R7 pulse", outValid, 1'b1);
    check("R7 data", outData, 8'h8F);
    @(negedge clk);
    check("R7 pulse one cycle", outValid, 1'b0);
    manT = 8'h01; manF = 8'h00;   // most pairs empty
    repeat (2) @(negedge clk);
    check("R6 partial empty keeps ack", rxAck, 1'b1);
    manT = 8'h00;
    @(negedge clk);
    check("R6 ack drops on empty", rxAck, 1'b0);
    manT = 8'h0F; manF = 8'h00;   // partial again after clear
    @(negedge clk);
    check("R6 hysteresis after clear", rxAck, 1'b0);
    manT = 8'h00;
    @(negedge clk);
  endtask

  task automatic testError;
    check("R8 no error before", protoErr, 1'b0);
    manT = 8'h04; manF = 8'h04;
    @(negedge clk);
    check("R8 error on 11", protoErr, 1'b1);
    manT = 8'h00; manF = 8'h00;
    repeat (3) @(negedge clk);
    check("R8 error sticky", protoErr, 1'b1);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R8 cleared by reset", protoErr, 1'b0);
    rxSel = 1'b0; ackSel = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic runStream(input int n, input bit reskew);
    rxCount = 0;
    streamOn = 1;
    for (int b = 0; b < W; b++) tap[b] = 2'($urandom_range(0, 3));
    for (int k = 0; k < n; k++) begin
      while (!inReady) @(negedge clk);
      if (reskew) begin
        repeat (4) @(negedge clk);
        for (int b = 0; b < W; b++) tap[b] = 2'($urandom_range(0, 3));
      end
      sent[k] = W'($urandom);
      inValid = 1'b1; inData = sent[k];
      @(negedge clk);
      inValid = 1'b0;
    end
    for (int t = 0; t < 200 && rxCount < n; t++) @(negedge clk);
    repeat (10) @(negedge clk);
    check("R10 count delivered", rxCount, n);
    check("R4 no valid swap", swapErr, 0);
    streamOn = 0;
    for (int b = 0; b < W; b++) tap[b] = 2'd0;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    testReset();
    testTransmit();
    testReceive();
    testError();
    runStream(40, 1'b1);
    runStream(40, 1'b0);
    check("R8 no error in stream", protoErr, 1'b0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule